// File: doc/BRIEF.md
# Edge-Triggered Time Base Capture

This block takes a snapshot of the slow taps of a free-running time base whenever a selected edge appears on one of its trigger pins. The taps presented to it are the 256, 128, 64 and 32 Hz outputs of a time base counter, which is generated elsewhere. Each trigger pin has its own capture register, so the two channels can timestamp independent events with a resolution of 1/256 s.

The active edge of each pin follows the pin's pad pull configuration. A pin pulled up idles high, so it captures on a falling edge. A pin pulled down idles low, so it captures on a rising edge. Software enables channels through a control register. It reads sticky capture flags and overrun bits from a status register, clears them by writing ones, and reads the captured tap values from two read-only registers.

Top module: `tbcap_top`

## Requirements
- R1: After reset, every register reads zero: control (address 0), status (address 1), capture channel 0 (address 2) and capture channel 1 (address 3).
- R2: A channel whose pull-up select is 1 captures on a falling pin edge. Its capture register then holds the tap vector, with bit 0 as the 32 Hz tap and bit 3 as the 256 Hz tap. The result is readable by the third rising clock edge after the pin changes, because of two synchronizer flops and one capture flop.
- R3: A channel whose pull-up select is 0 (pull-down) captures on a rising pin edge in the same way.
- R4: The edge opposite to a channel's active edge leaves its capture register and its status bits unchanged.
- R5: A channel whose enable bit is 0 ignores edges. Bit i of control address 0 enables channel i.
- R6: A capture sets channel i's sticky flag at status bit i. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R7: If an active edge arrives while a channel's flag is still set, the capture register is overwritten and the channel's overrun bit is set. Channel i's overrun bit is status bit 2+i and is cleared by writing 1 to it.
- R8: A capture on one channel leaves the other channel's capture register and status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tapIn | input | 4 | Time base taps, 32 Hz (bit 0) to 256 Hz (bit 3) |
| trigPin | input | 2 | Asynchronous trigger pins, one per channel |
| pullUp | input | 2 | Pad pull select per channel: 1 pull-up, 0 pull-down |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 8 | Register read data, combinational |

## Verification
The assertions assume that reset is held low long enough to clear all state before any property is sampled. They also assume that the tap vector is a registered signal that is sampled at the capture edge. The stimulus follows both assumptions. It changes the trigger pins and the taps on falling clock edges. It keeps pull selects constant while a channel is enabled, so that a change in pull select is never taken as a pin edge. It also holds the taps steady across each capture window, so the expected snapshot is unambiguous.

// File: rtl/tbcap_pkg.sv
package tbcap_pkg;
  parameter int CAP_CH = 2;

  typedef struct packed {
    logic [CAP_CH-1:0] capture;
  } tbcap_strobe_t;
endpackage

// File: rtl/tbcap_ctrl.sv
module tbcap_ctrl
  import tbcap_pkg::*;
#(
  parameter int NCH    = CAP_CH,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    trigPin,
  input  logic [NCH-1:0]    pullUp,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output tbcap_strobe_t     strb,
  output logic [NCH-1:0]    enable,
  output logic [NCH-1:0]    flag,
  output logic [NCH-1:0]    overrun
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1);

  logic [NCH-1:0] syncA, syncB, syncC;
  logic [NCH-1:0] hit;
  logic           ctrlWr, statWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncC <= '0;
    end else begin
      syncA <= trigPin;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign ctrlWr = wrEn && (wrAddr == CTRL_ADDR);
  assign statWr = wrEn && (wrAddr == STAT_ADDR);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      hit[i] = enable[i] & (pullUp[i] ? (syncC[i] & ~syncB[i])
                                      : (~syncC[i] & syncB[i]));
    end
    strb = '0;
    strb.capture[NCH-1:0] = hit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enable <= '0;
    else if (ctrlWr) enable <= wrData[NCH-1:0];
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : gChan
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          flag[g]    <= 1'b0;
          overrun[g] <= 1'b0;
        end else begin
          if (hit[g]) flag[g] <= 1'b1;
          else if (statWr && wrData[g]) flag[g] <= 1'b0;

          if (hit[g] && flag[g]) overrun[g] <= 1'b1;
          else if (statWr && wrData[NCH+g]) overrun[g] <= 1'b0;
        end
      end

      // a flag only rises on a channel that was enabled
      assert_flag_needs_enable_R5: assert property (
        @(posedge clk) disable iff (!rstN)
        $rose(flag[g]) |-> $past(enable[g]));

      // every capture strobe leaves the flag set
      assert_capture_sets_flag_R6: assert property (
        @(posedge clk) disable iff (!rstN)
        strb.capture[g] |=> flag[g]);

      // overrun only follows an already-set flag
      assert_overrun_after_flag_R7: assert property (
        @(posedge clk) disable iff (!rstN)
        $rose(overrun[g]) |-> $past(flag[g]));
    end
  endgenerate
endmodule

// File: rtl/tbcap_datapath.sv
module tbcap_datapath
  import tbcap_pkg::*;
#(
  parameter int NCH    = CAP_CH,
  parameter int TAP_W  = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TAP_W-1:0]  tapIn,
  input  tbcap_strobe_t     strb,
  input  logic [NCH-1:0]    enable,
  input  logic [NCH-1:0]    flag,
  input  logic [NCH-1:0]    overrun,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int CAP_BASE = 2;

  logic [TAP_W-1:0] capReg [NCH];

  generate
    for (genvar g = 0; g < NCH; g++) begin : gCap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) capReg[g] <= '0;
        else if (strb.capture[g]) capReg[g] <= tapIn;
      end

      assert_capture_loads_taps_R2: assert property (
        @(posedge clk) disable iff (!rstN)
        strb.capture[g] |=> (capReg[g] == $past(tapIn)));

      assert_capture_holds_R4: assert property (
        @(posedge clk) disable iff (!rstN)
        !strb.capture[g] |=> $stable(capReg[g]));
    end
  endgenerate

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(0)) rdData[NCH-1:0] = enable;
    if (rdAddr == ADDR_W'(1)) rdData[2*NCH-1:0] = {overrun, flag};
    for (int i = 0; i < NCH; i++) begin
      if (rdAddr == ADDR_W'(CAP_BASE + i)) rdData[TAP_W-1:0] = capReg[i];
    end
  end
endmodule

// File: rtl/tbcap_top.sv
module tbcap_top
  import tbcap_pkg::*;
#(
  parameter int NCH    = CAP_CH,
  parameter int TAP_W  = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(NCH + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TAP_W-1:0]  tapIn,
  input  logic [NCH-1:0]    trigPin,
  input  logic [NCH-1:0]    pullUp,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  tbcap_strobe_t  strb;
  logic [NCH-1:0] enable, flag, overrun;

  tbcap_ctrl #(.NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigPin(trigPin), .pullUp(pullUp),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .enable(enable), .flag(flag), .overrun(overrun));

  tbcap_datapath #(.NCH(NCH), .TAP_W(TAP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .tapIn(tapIn), .strb(strb),
    .enable(enable), .flag(flag), .overrun(overrun),
    .rdAddr(rdAddr), .rdData(rdData));
endmodule

// File: tb/tbcap_top_bench.sv
module tbcap_top_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] tapIn = 4'h0;
  logic [1:0] trigPin = 2'b01;
  logic [1:0] pullUp = 2'b01;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [1:0] addr;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  tbcap_top u_tbcap_top (
    .clk(clk), .rstN(rstN), .tapIn(tapIn), .trigPin(trigPin), .pullUp(pullUp),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData));

  // monitor: pops expected items and compares read data
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        rdAddr = it.addr;
        #1;
        checks++;
        if (rdData !== it.exp) begin
          errors++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, rdData, it.exp);
        end
      end
    end
  end

  task automatic expectReg(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setPin(input int ch, input logic v);
    @(negedge clk);
    trigPin[ch] = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    expectReg(2'd0, 8'h00, "R1 ctrl");
    expectReg(2'd1, 8'h00, "R1 status");
    expectReg(2'd2, 8'h00, "R1 cap0");
    expectReg(2'd3, 8'h00, "R1 cap1");
    drain();

    // R5 disabled channel ignores falling edge
    tapIn = 4'h3;
    setPin(0, 1'b0);
    expectReg(2'd1, 8'h00, "R5 status disabled");
    expectReg(2'd2, 8'h00, "R5 cap0 disabled");
    drain();
    setPin(0, 1'b1);

    busWrite(2'd0, 8'h03);
    expectReg(2'd0, 8'h03, "R5 ctrl enable");
    drain();

    // R2 pull-up channel captures on falling edge
    tapIn = 4'hA;
    setPin(0, 1'b0);
    expectReg(2'd1, 8'h01, "R2 status flag0");
    expectReg(2'd2, 8'h0A, "R2 cap0");
    drain();

    // R4 rising on pull-up channel ignored
    tapIn = 4'h5;
    setPin(0, 1'b1);
    expectReg(2'd2, 8'h0A, "R4 cap0 rising ignored");
    expectReg(2'd1, 8'h01, "R4 status unchanged");
    drain();

    // R3 pull-down channel captures on rising edge; R8 independence
    tapIn = 4'h6;
    setPin(1, 1'b1);
    expectReg(2'd3, 8'h06, "R3 cap1");
    expectReg(2'd1, 8'h03, "R3 status flag1");
    expectReg(2'd2, 8'h0A, "R8 cap0 untouched");
    drain();

    // R4 falling on pull-down channel ignored
    tapIn = 4'h7;
    setPin(1, 1'b0);
    expectReg(2'd3, 8'h06, "R4 cap1 falling ignored");
    drain();

    // R6 write 0 no effect, write 1 clears
    busWrite(2'd1, 8'h00);
    expectReg(2'd1, 8'h03, "R6 write zero keeps flags");
    drain();
    busWrite(2'd1, 8'h01);
    expectReg(2'd1, 8'h02, "R6 clear flag0");
    drain();

    // R7 overrun on channel 1 while flag set
    tapIn = 4'h9;
    setPin(1, 1'b1);
    expectReg(2'd3, 8'h09, "R7 cap1 overwritten");
    expectReg(2'd1, 8'h0A, "R7 overrun1 set");
    expectReg(2'd2, 8'h0A, "R8 cap0 untouched by ch1");
    drain();
    busWrite(2'd1, 8'h08);
    expectReg(2'd1, 8'h02, "R7 clear overrun1");
    drain();
    busWrite(2'd1, 8'h02);
    expectReg(2'd1, 8'h00, "R6 clear flag1");
    drain();

    // R5 disable channel 0 after use
    busWrite(2'd0, 8'h02);
    tapIn = 4'hC;
    setPin(0, 1'b0);
    expectReg(2'd2, 8'h0A, "R5 cap0 after disable");
    expectReg(2'd1, 8'h00, "R5 status after disable");
    drain();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule